// File: doc/BRIEF.md
# Absolute-Time Pulse Generator Channel

This block is a single output channel that emits one pulse whose leading and trailing edges are absolute times. Each edge time has a seconds part, a reference-cycle part and a sub-cycle fine part. The channel watches a free-running time base made of a seconds count and a cycle count. It raises its output when the time base reaches the start time and drops it when the time base reaches the end time. The fine parts are not acted on inside the block. They are presented on a tap output, so that an external delay line can place the edge inside the cycle.

The host loads six shadow fields through a small write port: start seconds, start cycles, start fine, end seconds, end cycles and end fine. It then pulses an update strobe, which copies all six fields into the working registers in one step. After that the host arms the channel and polls the triggered, done and error flags. Arming is refused when the start time leaves too little lead over the current time, or when the end time does not come after the start time. A separate calibration command produces a one-cycle pulse on the same output at the next measurement-period marker. An output polarity input selects whether the pulse is active high or active low.

Top module: `pgc_channel`

## Requirements
- R1: After reset the output is at its inactive level, the update-done flag is 1, the triggered and error flags are 0, and the tap output is 0.
- R2: Shadow writes use these select codes: 0 start seconds, 1 start cycles, 2 start fine, 3 end seconds, 4 end cycles, 5 end fine. Codes 6 and 7 are ignored. A shadow write never changes the working registers or the update-done flag until the next update strobe.
- R3: An update strobe makes update-done read 0 in the following cycle. All six fields are copied together, and update-done reads 1 again one cycle later.
- R4: Once the channel is armed, the output becomes active in the cycle after the time base equals the start seconds and cycles. It becomes inactive in the cycle after the time base equals the end seconds and cycles.
- R5: Arming clears the triggered flag. The flag reads 1 from the cycle after the end match until the next arm.
- R6: An arm whose start time is earlier than the current time base plus LEAD cycles (25 by default, which is 200 ns) sets the error flag. The channel then stays idle and never fires. An arm that does not fail this check, or the end-order check in R7, clears the error flag.
- R7: An arm whose end time is not later than its start time sets the error flag and does not fire.
- R8: With the polarity input at 1 the active output level is 1. With the polarity input at 0 the active output level is 0.
- R9: The tap output shows the start fine value while the channel waits for its start. It shows the end fine value while the pulse is active. It shows 0 otherwise.
- R10: A calibration command makes the output active for exactly one cycle. That cycle is the one following the next cycle in which the period marker is high.
- R11: Time comparisons and the lead check wrap the cycle field at CYC_MAX into the next second, so edges and lead windows may span a seconds boundary.
- R12: An arm request while the pulse is active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_sec | input | SEC_W | Time base seconds |
| tb_cyc | input | CYC_W | Time base cycle count, 0..CYC_MAX |
| wr_en | input | 1 | Shadow field write strobe |
| wr_sel | input | 3 | Shadow field select (codes in R2) |
| wr_data | input | SEC_W | Shadow field data, low bits used for narrower fields |
| upd_req | input | 1 | Copy shadow fields into working registers |
| arm_req | input | 1 | Arm the channel with the working times |
| cal_req | input | 1 | Request a calibration pulse |
| period_mark | input | 1 | Measurement-period start marker |
| pol | input | 1 | 1 active high, 0 active low |
| pulse_out | output | 1 | Channel output |
| tap_out | output | FINE_W | Fine value of the pending edge |
| upd_done | output | 1 | Working registers loaded |
| trig_done | output | 1 | Pulse has been produced since last arm |
| err_flag | output | 1 | Last arm was rejected |

## Verification
Corrupt working registers or a stuck state machine show up at once as a pulse edge that lands one or more cycles away from the time derived arithmetically from start and end. They can also show up as a wrong tap value in the very cycle after arming. A bad lead computation, especially across a seconds wrap, shows as a wrong error flag in the cycle right after the arm. It also shows as a missing or spurious pulse within about thirty cycles. A leaked shadow write shows as an error flag that is missing when an arm reuses old, now-past times.

// File: rtl/pgc_pkg.sv
// Package: shared state encoding and shadow field select codes for the
// pulse generator channel. Assumes three select bits cover six fields.
package pgc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_HIGH  = 2'd2,
        ST_FIRED = 2'd3
    } pgc_state_t;

    localparam int unsigned NUM_FIELDS = 6;
    localparam logic [2:0] SEL_ST_SEC = 3'd0;
    localparam logic [2:0] SEL_ST_CYC = 3'd1;
    localparam logic [2:0] SEL_ST_FIN = 3'd2;
    localparam logic [2:0] SEL_EN_SEC = 3'd3;
    localparam logic [2:0] SEL_EN_CYC = 3'd4;
    localparam logic [2:0] SEL_EN_FIN = 3'd5;
endpackage

// File: rtl/pgc_regs.sv
// Shadow and working register bank. Six shadow fields are written one at a
// time. An update strobe marks the bank busy for one cycle, and in that cycle
// all six fields move to the working set together.
// Assumes SEC_W is the widest field; narrower fields are truncated on output.
module pgc_regs #(
    parameter int unsigned SEC_W  = 32,
    parameter int unsigned CYC_W  = 28,
    parameter int unsigned FINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [SEC_W-1:0]  wr_data,
    input  logic              upd_req,
    output logic [SEC_W-1:0]  st_sec,
    output logic [CYC_W-1:0]  st_cyc,
    output logic [FINE_W-1:0] st_fin,
    output logic [SEC_W-1:0]  en_sec,
    output logic [CYC_W-1:0]  en_cyc,
    output logic [FINE_W-1:0] en_fin,
    output logic              upd_done
);
    import pgc_pkg::*;

    logic [SEC_W-1:0] shadow [NUM_FIELDS];
    logic [SEC_W-1:0] work   [NUM_FIELDS];
    logic             busy_q;

    // Busy lasts one cycle after each update request.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= upd_req;
    end

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        // Shadow field i captures host data on a matching select.
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow[i] <= '0;
            else if (wr_en && wr_sel == 3'(i))
                shadow[i] <= wr_data;
        end
        // Working field i follows its shadow only in the busy cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)
                work[i] <= '0;
            else if (busy_q)
                work[i] <= shadow[i];
        end
    end

    assign st_sec   = work[SEL_ST_SEC];
    assign st_cyc   = work[SEL_ST_CYC][CYC_W-1:0];
    assign st_fin   = work[SEL_ST_FIN][FINE_W-1:0];
    assign en_sec   = work[SEL_EN_SEC];
    assign en_cyc   = work[SEL_EN_CYC][CYC_W-1:0];
    assign en_fin   = work[SEL_EN_FIN][FINE_W-1:0];
    assign upd_done = !busy_q;
endmodule

// File: rtl/pgc_lead.sv
// Arm-time validity check. Forms the earliest acceptable start time, which is
// the time base plus LEAD cycles with a wrap into the next second past
// CYC_MAX. Flags a start earlier than that, and an end not after the start.
// Assumes LEAD <= CYC_MAX + 1 and time-base cycles never exceed CYC_MAX.
module pgc_lead #(
    parameter int unsigned SEC_W   = 32,
    parameter int unsigned CYC_W   = 28,
    parameter int unsigned CYC_MAX = 124999999,
    parameter int unsigned LEAD    = 25
) (
    input  logic [SEC_W-1:0] tb_sec,
    input  logic [CYC_W-1:0] tb_cyc,
    input  logic [SEC_W-1:0] st_sec,
    input  logic [CYC_W-1:0] st_cyc,
    input  logic [SEC_W-1:0] en_sec,
    input  logic [CYC_W-1:0] en_cyc,
    output logic             too_soon,
    output logic             bad_order
);
    localparam int unsigned SUM_W = CYC_W + 1;
    localparam logic [SUM_W-1:0] LEAD_V = SUM_W'(LEAD);
    localparam logic [SUM_W-1:0] MAX_V  = SUM_W'(CYC_MAX);
    localparam logic [SUM_W-1:0] MOD_V  = SUM_W'(CYC_MAX + 1);

    logic [SUM_W-1:0] sum;
    logic             wrap;
    logic [CYC_W-1:0] dl_cyc;
    logic [SEC_W-1:0] dl_sec;

    // Deadline = time base + LEAD, carrying into seconds.
    always_comb begin
        sum    = {1'b0, tb_cyc} + LEAD_V;
        wrap   = sum > MAX_V;
        dl_cyc = wrap ? CYC_W'(sum - MOD_V) : sum[CYC_W-1:0];
        dl_sec = tb_sec + SEC_W'(wrap);
    end

    // Lexicographic compares over {seconds, cycles}.
    assign too_soon  = {st_sec, st_cyc} <  {dl_sec, dl_cyc};
    assign bad_order = {en_sec, en_cyc} <= {st_sec, st_cyc};
endmodule

// File: rtl/pgc_core.sv
// Channel sequencer: idle, waiting for start, pulse high, fired. It also holds
// the calibration request and its one-cycle pulse, and it drives the output
// level, the tap and the status flags. Assumes the arm check inputs are
// combinational from the current time base.
module pgc_core #(
    parameter int unsigned SEC_W  = 32,
    parameter int unsigned CYC_W  = 28,
    parameter int unsigned FINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEC_W-1:0]  tb_sec,
    input  logic [CYC_W-1:0]  tb_cyc,
    input  logic [SEC_W-1:0]  st_sec,
    input  logic [CYC_W-1:0]  st_cyc,
    input  logic [FINE_W-1:0] st_fin,
    input  logic [SEC_W-1:0]  en_sec,
    input  logic [CYC_W-1:0]  en_cyc,
    input  logic [FINE_W-1:0] en_fin,
    input  logic              arm_req,
    input  logic              too_soon,
    input  logic              bad_order,
    input  logic              cal_req,
    input  logic              period_mark,
    input  logic              pol,
    output logic              pulse_out,
    output logic [FINE_W-1:0] tap_out,
    output logic              trig_done,
    output logic              err_flag,
    output logic              main_act,
    output logic              cal_act
);
    import pgc_pkg::*;

    pgc_state_t state_q;
    logic       cal_pend_q;
    logic       hit_start;
    logic       hit_end;
    logic       reject;

    assign hit_start = (tb_sec == st_sec) && (tb_cyc == st_cyc);
    assign hit_end   = (tb_sec == en_sec) && (tb_cyc == en_cyc);
    assign reject    = too_soon || bad_order;

    // Main sequencer with arm handling and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            trig_done <= 1'b0;
            err_flag  <= 1'b0;
        end else if (arm_req && state_q != ST_HIGH) begin
            err_flag  <= reject;
            trig_done <= 1'b0;
            state_q   <= reject ? ST_IDLE : ST_WAIT;
        end else begin
            case (state_q)
                ST_WAIT: if (hit_start) state_q <= ST_HIGH;
                ST_HIGH: if (hit_end) begin
                    state_q   <= ST_FIRED;
                    trig_done <= 1'b1;
                end
                default: state_q <= state_q;
            endcase
        end
    end

    // Calibration request held until the next period marker, then one pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_pend_q <= 1'b0;
            cal_act    <= 1'b0;
        end else begin
            cal_act    <= cal_pend_q && period_mark;
            cal_pend_q <= cal_req || (cal_pend_q && !period_mark);
        end
    end

    // Tap shows the fine value of the edge that comes next.
    always_comb begin
        case (state_q)
            ST_WAIT: tap_out = st_fin;
            ST_HIGH: tap_out = en_fin;
            default: tap_out = '0;
        endcase
    end

    assign main_act  = (state_q == ST_HIGH);
    assign pulse_out = pol ? (main_act || cal_act) : !(main_act || cal_act);
endmodule

// File: rtl/pgc_channel.sv
// Top of the absolute-time pulse generator channel. Connects the register
// bank, the arm check and the sequencer. Assumes the time base is supplied in
// the same clock domain and that its cycle field wraps at CYC_MAX.
module pgc_channel #(
    parameter int unsigned SEC_W   = 32,
    parameter int unsigned CYC_W   = 28,
    parameter int unsigned FINE_W  = 12,
    parameter int unsigned CYC_MAX = 124999999,
    parameter int unsigned LEAD    = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEC_W-1:0]  tb_sec,
    input  logic [CYC_W-1:0]  tb_cyc,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [SEC_W-1:0]  wr_data,
    input  logic              upd_req,
    input  logic              arm_req,
    input  logic              cal_req,
    input  logic              period_mark,
    input  logic              pol,
    output logic              pulse_out,
    output logic [FINE_W-1:0] tap_out,
    output logic              upd_done,
    output logic              trig_done,
    output logic              err_flag
);
    logic [SEC_W-1:0]  st_sec, en_sec;
    logic [CYC_W-1:0]  st_cyc, en_cyc;
    logic [FINE_W-1:0] st_fin, en_fin;
    logic              too_soon, bad_order;
    logic              main_act, cal_act;

    pgc_regs #(.SEC_W(SEC_W), .CYC_W(CYC_W), .FINE_W(FINE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .upd_req(upd_req),
        .st_sec(st_sec), .st_cyc(st_cyc), .st_fin(st_fin),
        .en_sec(en_sec), .en_cyc(en_cyc), .en_fin(en_fin),
        .upd_done(upd_done)
    );

    pgc_lead #(.SEC_W(SEC_W), .CYC_W(CYC_W), .CYC_MAX(CYC_MAX), .LEAD(LEAD)) u_lead (
        .tb_sec(tb_sec), .tb_cyc(tb_cyc),
        .st_sec(st_sec), .st_cyc(st_cyc),
        .en_sec(en_sec), .en_cyc(en_cyc),
        .too_soon(too_soon), .bad_order(bad_order)
    );

    pgc_core #(.SEC_W(SEC_W), .CYC_W(CYC_W), .FINE_W(FINE_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tb_sec(tb_sec), .tb_cyc(tb_cyc),
        .st_sec(st_sec), .st_cyc(st_cyc), .st_fin(st_fin),
        .en_sec(en_sec), .en_cyc(en_cyc), .en_fin(en_fin),
        .arm_req(arm_req), .too_soon(too_soon), .bad_order(bad_order),
        .cal_req(cal_req), .period_mark(period_mark), .pol(pol),
        .pulse_out(pulse_out), .tap_out(tap_out),
        .trig_done(trig_done), .err_flag(err_flag),
        .main_act(main_act), .cal_act(cal_act)
    );
endmodule

// File: rtl/pgc_channel_chk.sv
// Checker for the pulse generator channel, attached to every instance of the
// top module through bind. It relates strobes, time-base matches and flags
// over time.
module pgc_channel_chk #(
    parameter int unsigned SEC_W = 32,
    parameter int unsigned CYC_W = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEC_W-1:0] tb_sec,
    input logic [CYC_W-1:0] tb_cyc,
    input logic [SEC_W-1:0] st_sec,
    input logic [CYC_W-1:0] st_cyc,
    input logic [SEC_W-1:0] en_sec,
    input logic [CYC_W-1:0] en_cyc,
    input logic             upd_req,
    input logic             upd_done,
    input logic             arm_req,
    input logic             err_flag,
    input logic             trig_done,
    input logic             main_act,
    input logic             cal_act,
    input logic             period_mark
);
    p_upd_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_req |=> !upd_done);
    p_upd_finish_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_done && !upd_req) |=> upd_done);
    p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(arm_req));
    p_start_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_act) |-> ($past(tb_sec) == $past(st_sec) && $past(tb_cyc) == $past(st_cyc)));
    p_end_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(main_act) |-> ($past(tb_sec) == $past(en_sec) && $past(tb_cyc) == $past(en_cyc)));
    p_trig_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_done) |-> $past(main_act));
    p_cal_marker_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cal_act |-> $past(period_mark));
endmodule

bind pgc_channel pgc_channel_chk #(.SEC_W(SEC_W), .CYC_W(CYC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tb_sec(tb_sec), .tb_cyc(tb_cyc),
    .st_sec(st_sec), .st_cyc(st_cyc), .en_sec(en_sec), .en_cyc(en_cyc),
    .upd_req(upd_req), .upd_done(upd_done), .arm_req(arm_req),
    .err_flag(err_flag), .trig_done(trig_done), .main_act(main_act),
    .cal_act(cal_act), .period_mark(period_mark)
);

// File: tb/pgc_channel_test.sv
`timescale 1ns/1ps
// Bench: sweeps the lead, pulse width and polarity over a small cycle range
// (CMAX = 39), so that windows cross seconds often. It predicts every output
// from linear time arithmetic.
module pgc_channel_test;
    localparam int unsigned SEC_W = 32, CYC_W = 28, FINE_W = 12;
    localparam int unsigned CMAX = 39, LEAD = 25;
    localparam longint MOD = CMAX + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 0, upd_req = 0, arm_req = 0, cal_req = 0, period_mark = 0, pol = 1;
    logic [2:0] wr_sel = '0;
    logic [SEC_W-1:0] wr_data = '0;
    logic [SEC_W-1:0] tb_sec;
    logic [CYC_W-1:0] tb_cyc;
    logic pulse_out, upd_done, trig_done, err_flag;
    logic [FINE_W-1:0] tap_out;

    longint now_lin = 3 * MOD + 5;
    int total = 0, bad = 0;

    assign tb_sec = SEC_W'(now_lin / MOD);
    assign tb_cyc = CYC_W'(now_lin % MOD);

    always #2 clk = ~clk;

    pgc_channel #(.SEC_W(SEC_W), .CYC_W(CYC_W), .FINE_W(FINE_W),
                  .CYC_MAX(CMAX), .LEAD(LEAD)) uut (
        .clk(clk), .rst_n(rst_n), .tb_sec(tb_sec), .tb_cyc(tb_cyc),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .upd_req(upd_req), .arm_req(arm_req), .cal_req(cal_req),
        .period_mark(period_mark), .pol(pol), .pulse_out(pulse_out),
        .tap_out(tap_out), .upd_done(upd_done), .trig_done(trig_done),
        .err_flag(err_flag)
    );

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s t=%0d actual=%0d expected=%0d", req, now_lin, act, exp);
        end
    endtask

    // One clock: the edge consumes the inputs, then strobes clear and time advances.
    task automatic tick();
        @(posedge clk);
        #1;
        wr_en = 0; upd_req = 0; arm_req = 0; cal_req = 0; period_mark = 0;
        now_lin++;
    endtask

    task automatic wr(input logic [2:0] sel, input longint val);
        wr_en = 1; wr_sel = sel; wr_data = SEC_W'(val);
        tick();
    endtask

    // Eight ticks: six writes, the update, and one settle tick; checks R3.
    task automatic load(input longint s_lin, input longint e_lin,
                        input int fs, input int fe);
        wr(3'd0, s_lin / MOD); wr(3'd1, s_lin % MOD); wr(3'd2, fs);
        wr(3'd3, e_lin / MOD); wr(3'd4, e_lin % MOD); wr(3'd5, fe);
        chk("R2", upd_done, 1);
        upd_req = 1; tick();
        chk("R3", upd_done, 0);
        tick();
        chk("R3", upd_done, 1);
    endtask

    task automatic run_case(input int lead, input int w, input logic p);
        longint arm_t, s_lin, e_lin, seen;
        int fs, fe;
        logic exp_act, rej;
        string rq;
        arm_t = now_lin + 8;
        s_lin = arm_t + lead;
        e_lin = s_lin + w;
        fs = (lead * 37 + w) % 4096;
        fe = (4095 - lead * 11 - w) % 4096;
        rq = ((s_lin / MOD) != (arm_t / MOD) || (e_lin / MOD) != (s_lin / MOD)) ? "R11" : "R4";
        pol = p;
        load(s_lin, e_lin, fs, fe);
        arm_req = 1; tick();
        rej = (lead < LEAD);
        chk("R6", err_flag, rej);
        chk("R5", trig_done, 0);
        if (rej) begin
            for (int k = 0; k < lead + w + 3; k++) begin
                tick();
                chk("R6", pulse_out, !p);
            end
            chk("R6", trig_done, 0);
        end else begin
            chk("R9", tap_out, fs);
            while (now_lin <= e_lin + 1) begin
                seen = now_lin;
                tick();
                exp_act = (seen >= s_lin) && (seen < e_lin);
                chk(rq, pulse_out, p ? exp_act : !exp_act);
                chk("R8", pulse_out ^ exp_act, !p);
                chk("R9", tap_out, (seen < s_lin) ? fs : (exp_act ? fe : 0));
                chk("R5", trig_done, seen >= e_lin);
            end
        end
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        longint s_lin;
        tick(); tick();
        // R1: reset values.
        chk("R1", pulse_out, 0);
        chk("R1", upd_done, 1);
        chk("R1", trig_done, 0);
        chk("R1", err_flag, 0);
        chk("R1", tap_out, 0);
        rst_n = 1;
        tick();

        for (int pi = 0; pi < 2; pi++)
            for (int lead = 20; lead <= 32; lead++)
                for (int w = 1; w <= 3; w++)
                    run_case(lead, w, logic'(pi == 0));

        // R7: end equal to start is refused.
        pol = 1;
        s_lin = now_lin + 8 + 30;
        load(s_lin, s_lin, 5, 6);
        arm_req = 1; tick();
        chk("R7", err_flag, 1);
        for (int k = 0; k < 34; k++) begin
            tick();
            chk("R7", pulse_out, 0);
        end

        // R12: an arm during the pulse is ignored.
        s_lin = now_lin + 8 + 26;
        load(s_lin, s_lin + 4, 1, 2);
        arm_req = 1; tick();
        chk("R12", err_flag, 0);
        while (now_lin <= s_lin) tick();
        chk("R12", pulse_out, 1);
        arm_req = 1; tick();
        chk("R12", pulse_out, 1);
        chk("R12", err_flag, 0);
        while (now_lin <= s_lin + 4) tick();
        chk("R12", pulse_out, 0);
        chk("R12", trig_done, 1);

        // R2: shadow writes to a far-future time, including ignored codes, without an update.
        wr(3'd0, now_lin / MOD + 50); wr(3'd3, now_lin / MOD + 51);
        wr(3'd6, 0); wr(3'd7, 0);
        chk("R2", upd_done, 1);
        arm_req = 1; tick();
        chk("R2", err_flag, 1);
        chk("R2", tap_out, 0);

        // R10: the calibration pulse waits for the marker and lasts one cycle.
        pol = 1;
        cal_req = 1; tick();
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R10", pulse_out, 0);
        end
        period_mark = 1; tick();
        chk("R10", pulse_out, 1);
        tick();
        chk("R10", pulse_out, 0);
        period_mark = 1; tick();
        chk("R10", pulse_out, 0);

        summary();
    end
endmodule